// File: doc/BRIEF.md
# Interrupt Mask and Output Port Unit

This block holds the shared interrupt and parallel I/O logic of a dual-channel serial controller. Each channel reports a live transmit-ready and receive-ready condition. The block arranges them into an interrupt status byte, one nibble per channel. A write-only mask picks which of those conditions may raise the active-low interrupt request. The request stays low for as long as any unmasked condition is present. The status itself is never latched, so it clears when the channel condition goes away.

The block also owns an 8-bit output port. Software cannot write the port register directly. One write address sets bits: each 1 in the written byte sets that bit. A second write address clears bits: each 1 clears that bit. A 0 in either byte leaves the bit as it was. An output configuration register chooses, pin by pin, whether the pin follows the port register or an alternate source from a neighbouring block. A configuration of 0 gives every pin to the port register. The input port pins pass through a synchroniser and read back at their raw, active-low level.

The bus is byte-wide with a 4-bit address. Writes take effect on the clock edge where the write enable is high. Reads are combinational from the address.

Top module: `irq_oport_unit`

## Requirements
- R1: After reset the mask, the output port register and the output configuration are all 0, so `irqN` is 1 and `outPinsN` is 8'hFF.
- R2: Reading address 4'h5 returns the live status: bit 4n is `chanTxRdy[n]`, bit 4n+1 is `chanRxRdy[n]`, and bits 4n+2 and 4n+3 read 0.
- R3: `irqN` is a register. On each clock edge it takes the value 0 if (status AND mask) is nonzero, and 1 otherwise. It therefore follows a change of mask or status one cycle later.
- R4: Writing address 4'h5 loads the mask, and the mask cannot be read back. Mask bits at positions 4n+2 and 4n+3 never raise the interrupt.
- R5: Writing address 4'hE sets each output port bit whose data bit is 1 and leaves the other bits unchanged.
- R6: Writing address 4'hF clears each output port bit whose data bit is 1 and leaves the other bits unchanged.
- R7: Writing address 4'hD loads the output configuration. Where configuration bit i is 0, `outPinsN[i]` is the complement of port register bit i. Where it is 1, `outPinsN[i]` follows `altOutN[i]`.
- R8: Reading address 4'hD returns `inPinsN` at its raw level after a 2-flop synchroniser, so a low (asserted) pin reads 0. The value is valid from the second clock edge after the pin changes.
- R9: A write to any address other than 4'h5, 4'hD, 4'hE or 4'hF changes no state. A read of any such address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one byte per cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| chanTxRdy | input | 2 | Per-channel transmit-ready condition |
| chanRxRdy | input | 2 | Per-channel receive-ready condition |
| inPinsN | input | 8 | Input port pins, active low, asynchronous |
| altOutN | input | 8 | Alternate pin sources selected by configuration |
| outPinsN | output | 8 | Output port pins, active low |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The assertions check on every cycle that the interrupt request matches the masked status of the cycle before. They also check that a set write leaves every written 1 set, that a clear write leaves every written 1 cleared, that the port register holds steady without a set or clear write, and that at most one write strobe is active at a time. Only the bench's scenarios can show the pin-level results. These are the complemented port drive and its per-pin override, the nibble layout of the status read, the synchroniser delay on the input read-back, and the fact that unused mask bits and writes to undecoded addresses have no effect.

// File: rtl/irq_oport_pkg.sv
package irq_oport_pkg;
  typedef struct packed {
    logic maskWr;
    logic cfgWr;
    logic setWr;
    logic clrWr;
    logic rdStat;
    logic rdIn;
  } busStrobes_t;
endpackage

// File: rtl/irq_oport_ctrl.sv
module irq_oport_ctrl
  import irq_oport_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h5,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'hD,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 'hE,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobes_t       strb
);
  always_comb begin
    strb        = '0;
    strb.maskWr = busWrEn && (busAddr == MASK_ADDR);
    strb.cfgWr  = busWrEn && (busAddr == PORT_ADDR);
    strb.setWr  = busWrEn && (busAddr == SET_ADDR);
    strb.clrWr  = busWrEn && (busAddr == CLR_ADDR);
    strb.rdStat = (busAddr == MASK_ADDR);
    strb.rdIn   = (busAddr == PORT_ADDR);
  end

  // R9
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.maskWr, strb.cfgWr, strb.setWr, strb.clrWr}));
endmodule

// File: rtl/irq_oport_dp.sv
module irq_oport_dp
  import irq_oport_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] chanTxRdy,
  input  logic [NUM_CH-1:0] chanRxRdy,
  input  logic [DATA_W-1:0] inPinsN,
  input  logic [DATA_W-1:0] altOutN,
  output logic [DATA_W-1:0] outPinsN,
  output logic              irqN
);
  localparam int STAT_W = 4 * NUM_CH;

  logic [DATA_W-1:0] maskReg, cfgReg, portReg;
  logic [DATA_W-1:0] statVec;
  logic [DATA_W-1:0] inSync [SYNC_STAGES];
  logic              irqReg;

  // nibble-per-channel status layout
  always_comb begin
    statVec = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      statVec[4*ch]   = chanTxRdy[ch];
      statVec[4*ch+1] = chanRxRdy[ch];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      cfgReg  <= '0;
      portReg <= '0;
      irqReg  <= 1'b1;
    end else begin
      if (strb.maskWr) maskReg <= wrData;
      if (strb.cfgWr)  cfgReg  <= wrData;
      if (strb.setWr)  portReg <= portReg | wrData;
      if (strb.clrWr)  portReg <= portReg & ~wrData;
      irqReg <= ~|(statVec & maskReg);
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) inSync[s] <= '1;
        else if (s == 0) inSync[s] <= inPinsN;
        else inSync[s] <= inSync[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  generate
    for (genvar p = 0; p < DATA_W; p++) begin : g_pin
      assign outPinsN[p] = cfgReg[p] ? altOutN[p] : ~portReg[p];
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strb.rdStat)    rdData = statVec;
    else if (strb.rdIn) rdData = inSync[SYNC_STAGES-1];
  end

  assign irqN = irqReg;

  // R3
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqN == !$past(|(statVec & maskReg)));
  // R5
  set_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((portReg & $past(wrData)) == $past(wrData)));
  // R6
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((portReg & $past(wrData)) == '0));
  // R9
  port_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setWr && !strb.clrWr) |=> $stable(portReg));

  initial begin
    // R2
    stat_fit_chk: assert (STAT_W <= DATA_W);
  end
endmodule

// File: rtl/irq_oport_unit.sv
module irq_oport_unit
  import irq_oport_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_CH-1:0] chanTxRdy,
  input  logic [NUM_CH-1:0] chanRxRdy,
  input  logic [DATA_W-1:0] inPinsN,
  input  logic [DATA_W-1:0] altOutN,
  output logic [DATA_W-1:0] outPinsN,
  output logic              irqN
);
  busStrobes_t strb;

  irq_oport_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  irq_oport_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .rdData(busRdData),
    .chanTxRdy(chanTxRdy), .chanRxRdy(chanRxRdy), .inPinsN(inPinsN),
    .altOutN(altOutN), .outPinsN(outPinsN), .irqN(irqN)
  );
endmodule

// File: tb/irq_oport_unit_tb_top.sv
module irq_oport_unit_tb_top;
  logic clk = 0, rstN = 0;
  logic [3:0] busAddr = 0;
  logic busWrEn = 0;
  logic [7:0] busWrData = 0, busRdData;
  logic [1:0] chanTxRdy = 0, chanRxRdy = 0;
  logic [7:0] inPinsN = 8'hFF, altOutN = 8'hFF, outPinsN;
  logic irqN;

  int checks = 0, fails = 0;
  logic [7:0] mMask = 0, mCfg = 0, mPort = 0;

  always #2 clk = ~clk;

  irq_oport_unit dut_i (.*);

  function automatic logic [7:0] expStat(logic [1:0] tx, logic [1:0] rx);
    return {2'b00, rx[1], tx[1], 2'b00, rx[0], tx[0]};
  endfunction

  function automatic logic [7:0] expOut(logic [7:0] prt, logic [7:0] cfg, logic [7:0] alt);
    return (cfg & alt) | (~cfg & ~prt);
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
    case (a)
      4'h5: mMask = d;
      4'hD: mCfg  = d;
      4'hE: mPort = mPort | d;
      4'hF: mPort = mPort & ~d;
      default: ;
    endcase
  endtask

  task automatic busRead(logic [3:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic checkAll(string tag);
    logic [7:0] rd;
    repeat (2) @(negedge clk);
    check({tag, " R7 outPinsN"}, outPinsN, expOut(mPort, mCfg, altOutN));
    check({tag, " R3 irqN"}, {7'd0, irqN},
          {7'd0, ~|(expStat(chanTxRdy, chanRxRdy) & mMask)});
    busRead(4'h5, rd);
    check({tag, " R2 status"}, rd, expStat(chanTxRdy, chanRxRdy));
    busRead(4'hD, rd);
    check({tag, " R8 inport"}, rd, inPinsN);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outPinsN reset", outPinsN, 8'hFF);
    check("R1 irqN reset", {7'd0, irqN}, 8'd1);
    rstN = 1;
    @(negedge clk);
    chanTxRdy = 2'b11; chanRxRdy = 2'b11;
    checkAll("R1");

    // R5, R6 directed
    busWrite(4'hE, 8'hA5); checkAll("R5 set");
    check("R5 port", ~outPinsN, 8'hA5);
    busWrite(4'hF, 8'h05); check("R6 port", ~outPinsN, 8'hA0);
    busWrite(4'hE, 8'h00); check("R5 zero set", ~outPinsN, 8'hA0);
    busWrite(4'hF, 8'h00); check("R6 zero clr", ~outPinsN, 8'hA0);

    // R4 unused mask bits never raise irq; mask not readable
    busWrite(4'h5, 8'hCC); checkAll("R4 unused");
    check("R4 irq off", {7'd0, irqN}, 8'd1);
    chanTxRdy = 0; chanRxRdy = 0;
    busRead(4'h5, rd); check("R4 mask hidden", rd, 8'h00);
    // R3 rx ch0 with mask
    busWrite(4'h5, 8'h02); chanRxRdy = 2'b01; checkAll("R3 rx0");
    check("R3 irq on", {7'd0, irqN}, 8'd0);
    chanRxRdy = 0; checkAll("R3 clear");

    // R7 override
    altOutN = 8'h3C; busWrite(4'hD, 8'h0F); checkAll("R7 cfg");

    // R9 undecoded address
    busWrite(4'h3, 8'hFF); checkAll("R9 write");
    busRead(4'h7, rd); check("R9 read zero", rd, 8'h00);

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [3:0] a;
      op = $urandom % 6;
      case (op)
        0: busWrite(4'h5, 8'($urandom));
        1: busWrite(4'hE, 8'($urandom));
        2: busWrite(4'hF, 8'($urandom));
        3: busWrite(4'hD, 8'($urandom));
        4: begin
          a = 4'($urandom % 13);
          if (a == 4'h5) a = 4'hC;
          busWrite(a, 8'($urandom));
          busRead(a, rd); check("R9 undecoded read", rd, 8'h00);
        end
        default: begin
          @(negedge clk);
          chanTxRdy = 2'($urandom); chanRxRdy = 2'($urandom);
          inPinsN = 8'($urandom); altOutN = 8'($urandom);
        end
      endcase
      checkAll("rand");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule